// File: doc/BRIEF.md
# Transient Capture Sequencer

This block runs one acquisition of a four-channel transient recorder into a shared sample memory. Once triggered by an external or a software pulse, it lets a programmed number of sample strobes go by, then writes each later strobe's four samples into consecutive memory words. Writing ends on the first of four stop causes, and the cause is kept until software re-arms the block.

In threshold-trigger mode the first frames go into a circular pre-trigger area of programmable length, and that area wraps until the threshold comparator flags a hit. The frame that arrives with the hit, and every frame after it, are written from the end of the pre-trigger area onward. The slot of the oldest pre-trigger frame is reported so that the ring can be unrolled. The memory is an external single-port array. Strobes must be at least four clock cycles apart.

Top module: `tr_capture_seq`

## Requirements
- R1: After reset, state_o reads 0 (idle), wr_en_o and done_o are low and busy_o is low. The state codes are 0 idle, 1 delay, 2 pre-trigger, 3 capture and 4 done.
- R2: In idle, a high ext_trig_i or sw_trig_i moves the block out of idle. Triggers that arrive in any other state are ignored, and so are stop inputs that arrive in idle or done.
- R3: With delay_dly_i = N, the first N strobes after the trigger store nothing. The block then enters capture (or pre-trigger in threshold mode), and the next strobe is written to frame 0.
- R4: Each accepted strobe writes its four samples in four consecutive cycles. Channel k, taken from samples_i[16k+15:16k], goes to address frame*4+k.
- R5: ext_stop_i in delay, pre-trigger or capture moves the block to done with stop_reason_o = 0. It has priority over a software stop in the same cycle.
- R6: sw_stop_i on its own in an active state moves the block to done with stop_reason_o = 1.
- R7: Writing frame 2^(ADDR_W-2)-1 ends the capture with stop_reason_o = 2. This cause wins over a count limit that is reached on the same frame.
- R8: If max_frames_i is non-zero, the capture ends with stop_reason_o = 3 once that many post-trigger frames have been written. A value of 0 means no count limit. frame_cnt_o shows the number of post-trigger frames written.
- R9: In threshold mode (thr_mode_i = 1), frames without a hit are written to slots 0 to pre_len_i-1, wrapping back to 0. pre_len_i must be non-zero.
- R10: A strobe that arrives with thr_hit_i in pre-trigger is written to frame pre_len_i, and later frames follow it. pre_head_o then holds the pre-trigger slot that was next in line at the hit.
- R11: Done is held, with a stable stop_reason_o and no new writes, until sw_arm_i returns the block to idle.
- R12: A strobe that arrives in the same cycle as an effective stop is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| strobe_i | input | 1 | sample strobe, one cycle wide |
| samples_i | input | CH*DW | the four channel samples, channel 0 in the low bits |
| ext_trig_i | input | 1 | external start |
| sw_trig_i | input | 1 | software start |
| ext_stop_i | input | 1 | external stop |
| sw_stop_i | input | 1 | software stop |
| sw_arm_i | input | 1 | moves the block from done back to idle |
| thr_mode_i | input | 1 | 1 selects threshold-trigger mode |
| thr_hit_i | input | 1 | threshold reached, qualified by strobe_i |
| delay_dly_i | input | DLY_W | number of strobes skipped after the trigger |
| max_frames_i | input | ADDR_W-2 | post-trigger frame limit, 0 means no limit |
| pre_len_i | input | ADDR_W-2 | pre-trigger ring length in frames |
| wr_en_o | output | 1 | memory write enable |
| wr_addr_o | output | ADDR_W | memory word address |
| wr_data_o | output | DW | memory write data |
| state_o | output | 3 | state code |
| busy_o | output | 1 | high in delay, pre-trigger and capture |
| done_o | output | 1 | high in done |
| stop_reason_o | output | 2 | 0 external, 1 software, 2 overflow, 3 count |
| frame_cnt_o | output | ADDR_W-1 | post-trigger frames written |
| pre_head_o | output | ADDR_W-2 | oldest pre-trigger slot at the hit |

## Verification
The bench builds the block with ADDR_W = 8. That gives 64 frames, so running the memory out takes only a few hundred cycles, and a run can be set up where the overflow and the count limit fall on the same frame (pre-trigger length 60, limit 4). DLY_W stays at 8 because short delays are enough. In both modes the bench runs random delays, limits, ring lengths, hit points and stop injections, and compares the whole recorded memory image word by word against a model.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DELAY = 3'd1,
    ST_PRE   = 3'd2,
    ST_CAP   = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    RS_EXT = 2'd0,
    RS_SW  = 2'd1,
    RS_OVF = 2'd2,
    RS_CNT = 2'd3
  } stop_rs_e;
endpackage

// File: rtl/tr_seq_fsm.sv
module tr_seq_fsm
  import tr_pkg::*;
#(
  parameter int FRAME_W = 18,
  parameter int DLY_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic               ext_trig_i,
  input  logic               sw_trig_i,
  input  logic               ext_stop_i,
  input  logic               sw_stop_i,
  input  logic               sw_arm_i,
  input  logic               thr_mode_i,
  input  logic               hit_i,
  input  logic               last_i,
  input  logic [DLY_W-1:0]   delay_i,
  input  logic [FRAME_W-1:0] max_frames_i,
  output seq_state_e         state_o,
  output logic               start_o,
  output logic               accept_o,
  output stop_rs_e           reason_o,
  output logic [FRAME_W:0]   fcnt_o
);
  seq_state_e       state_q;
  stop_rs_e         reason_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [FRAME_W:0] fcnt_q, fcnt_n;
  logic             active, stop, in_post;
  seq_state_e       run_st;

  assign active   = (state_q == ST_DELAY) || (state_q == ST_PRE) || (state_q == ST_CAP);
  assign stop     = active && (ext_stop_i || sw_stop_i);
  assign start_o  = (state_q == ST_IDLE) && (ext_trig_i || sw_trig_i);
  assign run_st   = thr_mode_i ? ST_PRE : ST_CAP;
  assign accept_o = strobe_i && !stop && ((state_q == ST_PRE) || (state_q == ST_CAP));
  assign in_post  = (state_q == ST_CAP) || ((state_q == ST_PRE) && hit_i);
  assign fcnt_n   = fcnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      reason_q <= RS_EXT;
      dcnt_q   <= '0;
      fcnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_o) begin
          fcnt_q <= '0;
          dcnt_q <= delay_i;
          state_q <= (delay_i == '0) ? run_st : ST_DELAY;
        end
        ST_DONE: if (sw_arm_i) state_q <= ST_IDLE;
        default: begin
          if (stop) begin
            state_q  <= ST_DONE;
            reason_q <= ext_stop_i ? RS_EXT : RS_SW;
          end else if (state_q == ST_DELAY) begin
            if (strobe_i) begin
              dcnt_q <= dcnt_q - 1'b1;
              if (dcnt_q == DLY_W'(1)) state_q <= run_st;
            end
          end else if (accept_o && in_post) begin
            fcnt_q <= fcnt_n;
            if (last_i) begin
              state_q  <= ST_DONE;
              reason_q <= RS_OVF;
            end else if (max_frames_i != '0 && fcnt_n == {1'b0, max_frames_i}) begin
              state_q  <= ST_DONE;
              reason_q <= RS_CNT;
            end else begin
              state_q <= ST_CAP;
            end
          end
        end
      endcase
    end
  end

  assign state_o  = state_q;
  assign reason_o = reason_q;
  assign fcnt_o   = fcnt_q;
endmodule

// File: rtl/tr_frame_ptr.sv
module tr_frame_ptr #(
  parameter int FRAME_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               accept_i,
  input  logic               pre_i,
  input  logic               hit_i,
  input  logic [FRAME_W-1:0] pre_len_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               last_o,
  output logic [FRAME_W-1:0] head_o
);
  logic [FRAME_W-1:0] ptr_q, head_q, pre_last;
  logic               jump;

  assign jump     = pre_i && hit_i;
  assign pre_last = pre_len_i - 1'b1;
  assign frame_o  = jump ? pre_len_i : ptr_q;
  assign last_o   = (frame_o == {FRAME_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      head_q <= '0;
    end else if (start_i) begin
      ptr_q  <= '0;
      head_q <= '0;
    end else if (accept_i) begin
      if (pre_i && !hit_i) ptr_q <= (ptr_q == pre_last) ? '0 : ptr_q + 1'b1;
      else                 ptr_q <= frame_o + 1'b1;
      if (jump) head_q <= ptr_q;
    end
  end

  assign head_o = head_q;
endmodule

// File: rtl/tr_word_ser.sv
module tr_word_ser #(
  parameter int CH      = 4,
  parameter int DW      = 16,
  parameter int FRAME_W = 18,
  localparam int CH_W   = $clog2(CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [FRAME_W-1:0]      frame_i,
  input  logic [CH*DW-1:0]        samples_i,
  output logic                    wr_en_o,
  output logic [FRAME_W+CH_W-1:0] wr_addr_o,
  output logic [DW-1:0]           wr_data_o
);
  logic               busy_q;
  logic [CH_W-1:0]    idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CH*DW-1:0]   buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
      buf_q   <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      frame_q <= frame_i;
      buf_q   <= samples_i;
    end else if (busy_q) begin
      if (idx_q == CH_W'(CH - 1)) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign wr_en_o   = busy_q;
  assign wr_addr_o = {frame_q, idx_q};
  assign wr_data_o = buf_q[idx_q*DW +: DW];
endmodule

// File: rtl/tr_capture_seq.sv
module tr_capture_seq
  import tr_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CH       = 4,
  parameter int DW       = 16,
  parameter int DLY_W    = 16,
  localparam int CH_W    = $clog2(CH),
  localparam int FRAME_W = ADDR_W - CH_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [CH*DW-1:0]   samples_i,
  input  logic               ext_trig_i,
  input  logic               sw_trig_i,
  input  logic               ext_stop_i,
  input  logic               sw_stop_i,
  input  logic               sw_arm_i,
  input  logic               thr_mode_i,
  input  logic               thr_hit_i,
  input  logic [DLY_W-1:0]   delay_dly_i,
  input  logic [FRAME_W-1:0] max_frames_i,
  input  logic [FRAME_W-1:0] pre_len_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DW-1:0]      wr_data_o,
  output logic [2:0]         state_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [1:0]         stop_reason_o,
  output logic [FRAME_W:0]   frame_cnt_o,
  output logic [FRAME_W-1:0] pre_head_o
);
  seq_state_e         st;
  stop_rs_e           rs;
  logic               start, accept, last;
  logic [FRAME_W-1:0] frame;

  tr_seq_fsm #(.FRAME_W(FRAME_W), .DLY_W(DLY_W)) u_fsm (
    .clk_i, .rst_ni, .strobe_i, .ext_trig_i, .sw_trig_i, .ext_stop_i,
    .sw_stop_i, .sw_arm_i, .thr_mode_i,
    .hit_i(thr_hit_i), .last_i(last), .delay_i(delay_dly_i),
    .max_frames_i, .state_o(st), .start_o(start), .accept_o(accept),
    .reason_o(rs), .fcnt_o(frame_cnt_o)
  );

  tr_frame_ptr #(.FRAME_W(FRAME_W)) u_ptr (
    .clk_i, .rst_ni, .start_i(start), .accept_i(accept),
    .pre_i(st == ST_PRE), .hit_i(thr_hit_i), .pre_len_i,
    .frame_o(frame), .last_o(last), .head_o(pre_head_o)
  );

  tr_word_ser #(.CH(CH), .DW(DW), .FRAME_W(FRAME_W)) u_ser (
    .clk_i, .rst_ni, .load_i(accept), .frame_i(frame), .samples_i,
    .wr_en_o, .wr_addr_o, .wr_data_o
  );

  assign state_o       = st;
  assign stop_reason_o = rs;
  assign busy_o        = (st == ST_DELAY) || (st == ST_PRE) || (st == ST_CAP);
  assign done_o        = (st == ST_DONE);
endmodule

// File: rtl/tr_capture_seq_chk.sv
module tr_capture_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int CH     = 4,
  localparam int CH_W  = $clog2(CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_trig_i,
  input logic              sw_trig_i,
  input logic              ext_stop_i,
  input logic              sw_stop_i,
  input logic              sw_arm_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [2:0]        state_o,
  input logic [1:0]        stop_reason_o
);
  logic act;
  assign act = (state_o == 3'd1) || (state_o == 3'd2) || (state_o == 3'd3);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && !ext_trig_i && !sw_trig_i) |=> state_o == 3'd0);

  // R2
  trig_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && (ext_trig_i || sw_trig_i)) |=> state_o != 3'd0);

  // R5
  ext_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && ext_stop_i) |=> (state_o == 3'd4 && stop_reason_o == 2'd0));

  // R6
  sw_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && sw_stop_i && !ext_stop_i) |=> (state_o == 3'd4 && stop_reason_o == 2'd1));

  // R11
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !sw_arm_i) |=> (state_o == 3'd4 && $stable(stop_reason_o)));

  // R4
  word_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o[CH_W-1:0] != '0) |->
      ($past(wr_en_o) && wr_addr_o == $past(wr_addr_o) + 1'b1));
endmodule

bind tr_capture_seq tr_capture_seq_chk #(.ADDR_W(ADDR_W), .CH(CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_trig_i(ext_trig_i), .sw_trig_i(sw_trig_i),
  .ext_stop_i(ext_stop_i), .sw_stop_i(sw_stop_i), .sw_arm_i(sw_arm_i),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .state_o(state_o),
  .stop_reason_o(stop_reason_o)
);

// File: tb/sim_tr_capture_seq.sv
`timescale 1ns/1ps
module sim_tr_capture_seq;
  localparam int AW = 8, FW = 6, NW = 256;

  logic clk = 0, rst_ni = 0;
  logic strobe = 0, et = 0, st = 0, ep = 0, sp = 0, arm = 0, mode = 0, hit = 0;
  logic [63:0] smp = '0;
  logic [7:0]  dly = '0;
  logic [FW-1:0] maxf = '0, plen = 1;
  logic wr_en, busy, done;
  logic [AW-1:0] wr_addr;
  logic [15:0] wr_data;
  logic [2:0] state;
  logic [1:0] reason;
  logic [FW:0] fcnt;
  logic [FW-1:0] head;

  always #2 clk = ~clk;

  tr_capture_seq #(.ADDR_W(AW), .DLY_W(8)) u0 (
    .clk_i(clk), .rst_ni, .strobe_i(strobe), .samples_i(smp), .ext_trig_i(et),
    .sw_trig_i(st), .ext_stop_i(ep), .sw_stop_i(sp), .sw_arm_i(arm),
    .thr_mode_i(mode), .thr_hit_i(hit), .delay_dly_i(dly), .max_frames_i(maxf),
    .pre_len_i(plen), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .state_o(state), .busy_o(busy), .done_o(done), .stop_reason_o(reason),
    .frame_cnt_o(fcnt), .pre_head_o(head));

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] act_mem [NW];
  logic [15:0] exp_mem [NW];
  int m_st, m_dcnt, m_ptr, m_fcnt, m_rs, m_head;

  always @(negedge clk) if (rst_ni && wr_en) act_mem[wr_addr] = wr_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < NW; i++) begin act_mem[i] = 16'hDEAD; exp_mem[i] = 16'hDEAD; end
  endtask

  // bench model
  task automatic m_trig();
    if (m_st == 0) begin
      m_dcnt = dly; m_ptr = 0; m_fcnt = 0; m_head = 0;
      m_st = (dly == 0) ? (mode ? 2 : 3) : 1;
    end
  endtask

  task automatic m_stop(input bit e, input bit s);
    if ((e || s) && m_st >= 1 && m_st <= 3) begin m_st = 4; m_rs = e ? 0 : 1; end
  endtask

  task automatic m_strobe(input bit h, input logic [63:0] s);
    int fr;
    bit post;
    if (m_st == 1) begin
      m_dcnt--;
      if (m_dcnt == 0) m_st = mode ? 2 : 3;
    end else if (m_st == 2 || m_st == 3) begin
      post = (m_st == 3) || h;
      if (m_st == 2 && h) begin m_head = m_ptr; fr = plen; end else fr = m_ptr;
      for (int k = 0; k < 4; k++) exp_mem[fr*4+k] = s[k*16 +: 16];
      if (!post) m_ptr = (m_ptr == plen - 1) ? 0 : m_ptr + 1;
      else begin
        m_ptr = fr + 1; m_fcnt++; m_st = 3;
        if (fr == 63) begin m_st = 4; m_rs = 2; end
        else if (maxf != 0 && m_fcnt == maxf) begin m_st = 4; m_rs = 3; end
      end
    end
  endtask

  // drivers: inputs change at negedge, one cycle wide
  task automatic pulse(input bit t_e, t_s, p_e, p_s, a, stb, h);
    logic [63:0] s;
    s = {$urandom, $urandom};
    @(negedge clk);
    et = t_e; st = t_s; ep = p_e; sp = p_s; arm = a; strobe = stb; hit = h; smp = s;
    if (a && m_st == 4) m_st = 0;
    if (t_e || t_s) m_trig();
    m_stop(p_e, p_s);
    if (stb) m_strobe(h, s);
    @(negedge clk);
    {et, st, ep, sp, arm, strobe, hit} = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input bit md, input int d, input int mf, input int pl);
    mode = md; dly = 8'(d); maxf = FW'(mf); plen = FW'(pl);
  endtask

  task automatic check_run(input string tag);
    int bad;
    repeat (3) @(negedge clk);
    bad = 0;
    for (int i = 0; i < NW; i++) if (act_mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, {tag, " R4 R3 R9 memory image"}, bad, 0);
    chk(state == 3'(m_st), {tag, " R11 state"}, state, m_st);
    if (m_st == 4) chk(reason == 2'(m_rs), {tag, " R5 R6 R7 R8 reason"}, reason, m_rs);
    if (m_st >= 2) chk(fcnt == (FW+1)'(m_fcnt), {tag, " R8 frame_cnt"}, fcnt, m_fcnt);
    if (mode && m_st >= 3) chk(head == FW'(m_head), {tag, " R10 pre_head"}, head, m_head);
  endtask

  task automatic rearm();
    pulse(0, 0, 0, 0, 1, 0, 0);
    clear_mem();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_st = 0; m_rs = 0;
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state == 0, "R1 state", state, 0);
    chk(!wr_en && !done && !busy, "R1 outputs", {wr_en, done, busy}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R2: stop in idle ignored
    pulse(0, 0, 1, 1, 0, 1, 0);
    chk(state == 0, "R2 stop in idle", state, 0);

    // R3 R8: delay 3, count 5
    cfg(0, 3, 5, 1);
    pulse(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) pulse(0, 0, 0, 0, 0, 1, 0);
    check_run("dir1");
    chk(reason == 3 && fcnt == 5, "R8 count stop", reason, 3);

    // R11 R2: trigger in done ignored, then arm
    pulse(1, 1, 0, 0, 0, 1, 0);
    chk(state == 4, "R11 trig in done", state, 4);
    rearm();
    chk(state == 0, "R11 arm to idle", state, 0);

    // R7: overflow without limit
    cfg(0, 0, 0, 1);
    pulse(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) pulse(0, 0, 0, 0, 0, 1, 0);
    check_run("dir2");
    chk(reason == 2, "R7 overflow", reason, 2);
    rearm();

    // R7 priority over R8 on same frame
    cfg(1, 0, 4, 60);
    pulse(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 65; i++) pulse(0, 0, 0, 0, 0, 1, 0);
    pulse(0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 5; i++) pulse(0, 0, 0, 0, 0, 1, 0);
    check_run("dir3");
    chk(reason == 2 && fcnt == 4, "R7 beats R8", reason, 2);
    rearm();

    // R5: both stops, external wins
    cfg(0, 0, 0, 1);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1, 0);
    pulse(0, 0, 1, 1, 0, 0, 0);
    check_run("dir4");
    chk(reason == 0, "R5 ext priority", reason, 0);
    rearm();

    // R6 R12: software stop with a simultaneous strobe
    pulse(0, 1, 0, 0, 0, 0, 0);
    pulse(0, 0, 0, 0, 0, 1, 0);
    pulse(0, 0, 0, 1, 0, 1, 0);
    check_run("dir5");
    chk(reason == 1 && fcnt == 1, "R12 strobe with stop", fcnt, 1);
    rearm();

    // random runs
    for (int r = 0; r < 40; r++) begin
      int ns, hp;
      cfg($urandom_range(0, 1), $urandom_range(0, 5), $urandom_range(0, 20),
          $urandom_range(1, 20));
      ns = $urandom_range(0, 45);
      hp = $urandom_range(0, 40);
      pulse($urandom_range(0, 1), 1, 0, 0, 0, 0, 0);
      for (int i = 0; i < ns; i++) begin
        if ($urandom_range(0, 30) == 0) begin
          bit e = $urandom_range(0, 1);
          pulse(0, 0, e, !e || $urandom_range(0, 1), 0, $urandom_range(0, 1), 0);
        end else begin
          pulse(0, 0, 0, 0, 0, 1, (i >= hp) && $urandom_range(0, 2) == 0);
        end
      end
      check_run($sformatf("rnd%0d", r));
      rearm();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule